// File: doc/BRIEF.md
# Two-Segment Transmit Stream Protocol Monitor

This block watches a 128-bit transmit stream that is carried as two 64-bit segments. Each segment has its own enable, packet-start, packet-end and error sideband bits. A shared `tvalid`/`tready` pair sits over both segments. A packet may begin or finish in either segment. One packet may also close in the lower segment while the next one opens in the upper segment of the same cycle. The monitor only observes the bus and drives nothing back onto it.

On every cycle the segments are evaluated in order, lower segment first, to update an open-packet state. Each kind of protocol breach sets its own sticky flag. The flags hold until a synchronous clear or a reset. The block also keeps a count of completed packets, which a testbench can compare against what it sent.

The underflow flag covers a sink that is ready while a packet is open but the source offers no segment transfer in that cycle. The byte-empty count and the payload are not interpreted, so they are not inputs.

Top module: `seg_stream_monitor`

## Requirements
- R1: A segment transfers only in a cycle where `tvalid`, `tready` and that segment's enable bit are all high. Sideband bits on a segment that does not transfer change no state, no flag and no count. Bit 0 of every per-segment vector belongs to the lower segment and bit 1 to the upper one.
- R2: `pkt_open` goes high after a cycle with a start transfer and goes low after a cycle with an end transfer. The lower segment is applied before the upper one. A start and an end on the same segment therefore leave the packet closed. An end in the lower segment followed by a start in the upper segment leaves it open, and sets no flag.
- R3: `pkt_count` increases by one for each end transfer that closes an open packet. It changes in no other cycle, and `clr` does not affect it.
- R4: `flag_multi_sop` is set when more than one segment carries a start transfer in a single cycle.
- R5: `flag_multi_eop` is set when more than one segment carries an end transfer in a single cycle.
- R6: `flag_sop_open` is set when a start transfer arrives while a packet is already open, counting any packet opened by a lower segment in the same cycle.
- R7: `flag_orphan` is set when a transfer without a start bit arrives on a segment while no packet is open. This covers both payload data and end transfers.
- R8: `flag_err_mid` is set when a transferred segment has its error bit high but its end bit low. An error bit on an end transfer, or on a segment that does not transfer, sets nothing.
- R9: `flag_gap` is set when the upper segment transfers while the lower one is disabled, in a cycle that starts with a packet open.
- R10: `flag_underflow` is set when `tready` is high and a packet is open at the start of the cycle, but no segment transfers. This includes the case where `tvalid` is high with both enables low.
- R11: Every flag stays set until `clr` is sampled high. `clr` zeroes all flags at the next edge and takes priority over any violation in the same cycle. It leaves `pkt_open` unchanged.
- R12: While `rst_n` is low, all flags, `pkt_open` and `pkt_count` are zero. Reset release takes effect synchronously. Each output reflects a bus cycle from the clock edge that ends that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| clr | input | 1 | Synchronous clear of all sticky flags |
| tready | input | 1 | Sink ready, observed |
| tvalid | input | 1 | Source valid, observed |
| seg_en | input | 2 | Per-segment enable |
| seg_sop | input | 2 | Per-segment packet start |
| seg_eop | input | 2 | Per-segment packet end |
| seg_err | input | 2 | Per-segment packet error marker |
| pkt_open | output | 1 | A packet is currently open |
| flag_multi_sop | output | 1 | Sticky: more than one start in a cycle |
| flag_multi_eop | output | 1 | Sticky: more than one end in a cycle |
| flag_sop_open | output | 1 | Sticky: start while a packet is open |
| flag_orphan | output | 1 | Sticky: data or end with no open packet |
| flag_err_mid | output | 1 | Sticky: error bit on a non-end transfer |
| flag_gap | output | 1 | Sticky: upper segment used with lower idle inside a packet |
| flag_underflow | output | 1 | Sticky: ready cycle with no data inside a packet |
| pkt_count | output | 16 | Completed packet count |

## Verification
A wrong open-packet state shows up at the ports one edge after the faulty cycle. It appears as a wrong `pkt_open` and as a missing or spurious orphan, nested-start or underflow flag on the next transfer. The count then drifts at the next end transfer. If segment order is evaluated wrongly, the same-cycle hand-over from one packet to the next produces a false nested-start or orphan flag in that very cycle. Dropped stickiness is exposed on the first clean cycle after a violation, and a weak clear is exposed by a violation presented together with `clr`.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

  // Result of evaluating one segment against the packet state
  typedef struct packed {
    logic sop_open;   // start seen while a packet was open
    logic orphan;     // non-start transfer with no open packet
    logic err_mid;    // error bit on a non-end transfer
    logic closed;     // end transfer closed an open packet
  } seg_evt_t;

  // Flag vector bit positions
  localparam int unsigned FL_MULTI_SOP = 0;
  localparam int unsigned FL_MULTI_EOP = 1;
  localparam int unsigned FL_SOP_OPEN  = 2;
  localparam int unsigned FL_ORPHAN    = 3;
  localparam int unsigned FL_ERR_MID   = 4;
  localparam int unsigned FL_GAP       = 5;
  localparam int unsigned FL_UNDERFLOW = 6;
  localparam int unsigned NFLAG        = 7;

endpackage

// File: rtl/ssm_seg_step.sv
module ssm_seg_step (
  input  logic              open_in,
  input  logic              xfer,
  input  logic              sop,
  input  logic              eop,
  input  logic              err,
  output logic              open_out,
  output ssm_pkg::seg_evt_t evt
);

  logic open_mid;

  always_comb begin
    evt      = '0;
    open_mid = open_in;
    open_out = open_in;
    if (xfer) begin
      if (sop) begin
        evt.sop_open = open_in;
        open_mid     = 1'b1;
      end else begin
        evt.orphan   = ~open_in;
      end
      if (eop) begin
        evt.closed = open_mid;
        open_out   = 1'b0;
      end else begin
        evt.err_mid = err;
        open_out    = open_mid;
      end
    end
  end

endmodule

// File: rtl/ssm_flag_bank.sv
module ssm_flag_bank #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] q
);

  logic [N-1:0] d;
  logic         en;

  always_comb begin
    en = clr | (|set);
    d  = clr ? '0 : (q | set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end

endmodule

// File: rtl/ssm_pkt_counter.sv
module ssm_pkt_counter #(
  parameter int unsigned NSEG  = 2,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSEG-1:0]  inc,
  output logic [CNT_W-1:0] cnt
);

  localparam int unsigned ADD_W = $clog2(NSEG + 1);

  logic [ADD_W-1:0] add;
  logic [CNT_W-1:0] cnt_d;
  logic             en;

  always_comb begin
    add = '0;
    for (int i = 0; i < NSEG; i++) begin
      add = add + ADD_W'(inc[i]);
    end
    en    = |inc;
    cnt_d = cnt + CNT_W'(add);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/seg_stream_monitor.sv
module seg_stream_monitor #(
  parameter int unsigned NSEG  = 2,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tready,
  input  logic             tvalid,
  input  logic [NSEG-1:0]  seg_en,
  input  logic [NSEG-1:0]  seg_sop,
  input  logic [NSEG-1:0]  seg_eop,
  input  logic [NSEG-1:0]  seg_err,
  output logic             pkt_open,
  output logic             flag_multi_sop,
  output logic             flag_multi_eop,
  output logic             flag_sop_open,
  output logic             flag_orphan,
  output logic             flag_err_mid,
  output logic             flag_gap,
  output logic             flag_underflow,
  output logic [CNT_W-1:0] pkt_count
);

  import ssm_pkg::*;

  // Reset: asserted asynchronously, released after two edges
  logic [1:0] rst_sr;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sr <= 2'b00;
    end else begin
      rst_sr <= {rst_sr[0], 1'b1};
    end
  end
  assign rst_q_n = rst_sr[1];

  // Per-segment transfer qualification
  logic            fire;
  logic [NSEG-1:0] xfer;
  logic [NSEG:0]   open_ch;
  logic [NSEG-1:0] gap_v;
  logic [NSEG-1:0] closed_v;
  logic [NSEG-1:0] sop_open_v;
  logic [NSEG-1:0] orphan_v;
  logic [NSEG-1:0] err_mid_v;
  seg_evt_t        evt [NSEG];
  logic            open_q;
  logic            open_d;
  logic            open_en;

  assign fire       = tvalid & tready;
  assign open_ch[0] = open_q;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    assign xfer[g] = fire & seg_en[g];

    ssm_seg_step u_step (
      .open_in  (open_ch[g]),
      .xfer     (xfer[g]),
      .sop      (seg_sop[g]),
      .eop      (seg_eop[g]),
      .err      (seg_err[g]),
      .open_out (open_ch[g+1]),
      .evt      (evt[g])
    );

    assign closed_v[g]   = evt[g].closed;
    assign sop_open_v[g] = evt[g].sop_open;
    assign orphan_v[g]   = evt[g].orphan;
    assign err_mid_v[g]  = evt[g].err_mid;

    if (g == 0) begin : g_first
      assign gap_v[g] = 1'b0;
    end else begin : g_rest
      assign gap_v[g] = open_q & xfer[g] & ~seg_en[g-1];
    end
  end

  // Open-packet register, enabled only on bus transfers
  assign open_en = fire;
  assign open_d  = open_ch[NSEG];

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      open_q <= 1'b0;
    end else if (open_en) begin
      open_q <= open_d;
    end
  end

  // Violation set vector
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flag_q;

  always_comb begin
    flag_set               = '0;
    flag_set[FL_MULTI_SOP] = $countones(xfer & seg_sop) > 1;
    flag_set[FL_MULTI_EOP] = $countones(xfer & seg_eop) > 1;
    flag_set[FL_SOP_OPEN]  = |sop_open_v;
    flag_set[FL_ORPHAN]    = |orphan_v;
    flag_set[FL_ERR_MID]   = |err_mid_v;
    flag_set[FL_GAP]       = |gap_v;
    flag_set[FL_UNDERFLOW] = tready & open_q & ~(|xfer);
  end

  ssm_flag_bank #(.N(NFLAG)) u_flags (
    .clk   (clk),
    .rst_n (rst_q_n),
    .clr   (clr),
    .set   (flag_set),
    .q     (flag_q)
  );

  ssm_pkt_counter #(.NSEG(NSEG), .CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_q_n),
    .inc   (closed_v),
    .cnt   (pkt_count)
  );

  assign pkt_open       = open_q;
  assign flag_multi_sop = flag_q[FL_MULTI_SOP];
  assign flag_multi_eop = flag_q[FL_MULTI_EOP];
  assign flag_sop_open  = flag_q[FL_SOP_OPEN];
  assign flag_orphan    = flag_q[FL_ORPHAN];
  assign flag_err_mid   = flag_q[FL_ERR_MID];
  assign flag_gap       = flag_q[FL_GAP];
  assign flag_underflow = flag_q[FL_UNDERFLOW];

endmodule

// File: rtl/ssm_checker.sv
module ssm_checker #(
  parameter int unsigned NSEG  = 2,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             tready,
  input logic             tvalid,
  input logic [NSEG-1:0]  seg_en,
  input logic [NSEG-1:0]  seg_sop,
  input logic [NSEG-1:0]  seg_eop,
  input logic             pkt_open,
  input logic [6:0]       flags,
  input logic [CNT_W-1:0] pkt_count
);

  // R1
  open_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tvalid && tready) |=> $stable(pkt_open));

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tvalid && tready && (|(seg_en & seg_eop))) |=> $stable(pkt_count));

  // R4
  multi_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tvalid && tready && !clr && $countones(seg_en & seg_sop) > 1) |=> flags[0]);

  // R5
  multi_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tvalid && tready && !clr && $countones(seg_en & seg_eop) > 1) |=> flags[1]);

  // R6
  sop_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tvalid && tready && !clr && pkt_open && seg_en[0] && seg_sop[0]) |=> flags[2]);

  // R10
  underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tready && pkt_open && !clr && !(tvalid && (|seg_en))) |=> flags[6]);

  // R11
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (flags == 7'd0));

  // R11
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flags & $past(flags)) == $past(flags)));

endmodule

bind seg_stream_monitor ssm_checker #(.NSEG(NSEG), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .clr       (clr),
  .tready    (tready),
  .tvalid    (tvalid),
  .seg_en    (seg_en),
  .seg_sop   (seg_sop),
  .seg_eop   (seg_eop),
  .pkt_open  (pkt_open),
  .flags     ({flag_underflow, flag_gap, flag_err_mid, flag_orphan,
               flag_sop_open, flag_multi_eop, flag_multi_sop}),
  .pkt_count (pkt_count)
);

// File: tb/tb_seg_stream_monitor.sv
module tb_seg_stream_monitor;

  logic        clk;
  logic        rst_n;
  logic        clr;
  logic        tready;
  logic        tvalid;
  logic [1:0]  seg_en;
  logic [1:0]  seg_sop;
  logic [1:0]  seg_eop;
  logic [1:0]  seg_err;
  logic        pkt_open;
  logic        flag_multi_sop;
  logic        flag_multi_eop;
  logic        flag_sop_open;
  logic        flag_orphan;
  logic        flag_err_mid;
  logic        flag_gap;
  logic        flag_underflow;
  logic [15:0] pkt_count;

  seg_stream_monitor dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .clr            (clr),
    .tready         (tready),
    .tvalid         (tvalid),
    .seg_en         (seg_en),
    .seg_sop        (seg_sop),
    .seg_eop        (seg_eop),
    .seg_err        (seg_err),
    .pkt_open       (pkt_open),
    .flag_multi_sop (flag_multi_sop),
    .flag_multi_eop (flag_multi_eop),
    .flag_sop_open  (flag_sop_open),
    .flag_orphan    (flag_orphan),
    .flag_err_mid   (flag_err_mid),
    .flag_gap       (flag_gap),
    .flag_underflow (flag_underflow),
    .pkt_count      (pkt_count)
  );

  // Flag bits: 0 multi_sop, 1 multi_eop, 2 sop_open, 3 orphan,
  //            4 err_mid, 5 gap, 6 underflow
  localparam logic [6:0] F_MSOP = 7'h01;
  localparam logic [6:0] F_MEOP = 7'h02;
  localparam logic [6:0] F_SOPO = 7'h04;
  localparam logic [6:0] F_ORPH = 7'h08;
  localparam logic [6:0] F_ERRM = 7'h10;
  localparam logic [6:0] F_GAP  = 7'h20;
  localparam logic [6:0] F_UNDF = 7'h40;

  typedef struct {
    logic [6:0]  fl;
    logic        op;
    logic [15:0] cn;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          checks;
  int          errors;
  logic [6:0]  m_flags;
  logic [15:0] m_cnt;
  logic        done;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [6:0] obs_flags();
    return {flag_underflow, flag_gap, flag_err_mid, flag_orphan,
            flag_sop_open, flag_multi_eop, flag_multi_sop};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: one bus cycle, with the expected outcome pushed to the scoreboard
  task automatic step(input logic rdy, input logic vld, input logic [1:0] en,
                      input logic [1:0] sop, input logic [1:0] eop,
                      input logic [1:0] err, input logic c,
                      input logic [6:0] newf, input logic exp_open,
                      input int inc, input string tag);
    exp_t e;
    @(negedge clk);
    tready  = rdy;
    tvalid  = vld;
    seg_en  = en;
    seg_sop = sop;
    seg_eop = eop;
    seg_err = err;
    clr     = c;
    if (c) m_flags = '0;
    else   m_flags = m_flags | newf;
    m_cnt = m_cnt + 16'(inc);
    e.fl  = m_flags;
    e.op  = exp_open;
    e.cn  = m_cnt;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input logic exp_open, input string tag);
    step(1'b0, 1'b0, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0, '0, exp_open, 0, tag);
  endtask

  task automatic clear(input logic exp_open, input string tag);
    step(1'b0, 1'b0, 2'b00, 2'b00, 2'b00, 2'b00, 1'b1, '0, exp_open, 0, tag);
  endtask

  // Monitor: sample two time units after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.tag, "flags", 16'(obs_flags()), 16'(e.fl));
        chk(e.tag, "pkt_open", 16'(pkt_open), 16'(e.op));
        chk(e.tag, "pkt_count", pkt_count, e.cn);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    checks  = 0;
    errors  = 0;
    done    = 1'b0;
    m_flags = '0;
    m_cnt   = '0;
    rst_n   = 1'b0;
    clr     = 1'b0;
    tready  = 1'b0;
    tvalid  = 1'b0;
    seg_en  = '0;
    seg_sop = '0;
    seg_eop = '0;
    seg_err = '0;
    repeat (3) @(negedge clk);
    // R12: reset values
    chk("R12", "flags", 16'(obs_flags()), 16'h0);
    chk("R12", "pkt_open", 16'(pkt_open), 16'h0);
    chk("R12", "pkt_count", pkt_count, 16'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R3: packet across three cycles, ending in the upper segment
    step(1,1,2'b11,2'b01,2'b00,2'b00,0,'0,1,0,"R2_open");
    step(1,1,2'b11,2'b00,2'b00,2'b00,0,'0,1,0,"R2_mid");
    step(1,1,2'b11,2'b00,2'b10,2'b00,0,'0,0,1,"R3_close");

    // R2: end in lower segment and start in upper segment of one cycle
    step(1,1,2'b11,2'b01,2'b00,2'b00,0,'0,1,0,"R2_straddle_a");
    step(1,1,2'b11,2'b10,2'b01,2'b00,0,'0,1,1,"R2_straddle_b");
    step(1,1,2'b01,2'b00,2'b01,2'b00,0,'0,0,1,"R2_straddle_c");

    // R2: start and end in the same upper segment
    step(1,1,2'b10,2'b10,2'b10,2'b00,0,'0,0,1,"R2_single_seg");

    // R1: no transfer without tready or without tvalid
    step(0,1,2'b11,2'b01,2'b00,2'b00,0,'0,0,0,"R1_not_ready");
    step(1,0,2'b11,2'b01,2'b00,2'b00,0,'0,0,0,"R1_not_valid");
    step(1,1,2'b01,2'b01,2'b00,2'b00,0,'0,1,0,"R1_open");
    idle(1, "R10_no_ready_no_flag");
    // R10: valid with no enabled segment while open
    step(1,1,2'b00,2'b00,2'b00,2'b00,0,F_UNDF,1,0,"R10_no_enable");
    // R11: clear keeps the packet open
    clear(1, "R11_clear_keeps_open");
    step(1,1,2'b01,2'b00,2'b01,2'b00,0,'0,0,1,"R3_close2");

    // R10: tready without tvalid inside a packet
    step(1,1,2'b01,2'b01,2'b00,2'b00,0,'0,1,0,"R10_open");
    step(1,0,2'b11,2'b00,2'b00,2'b00,0,F_UNDF,1,0,"R10_underflow");
    step(1,1,2'b01,2'b00,2'b01,2'b00,0,'0,0,1,"R11_sticky_underflow");
    idle(0, "R11_sticky_idle");
    clear(0, "R11_clear");

    // R4 R6: two starts in one cycle
    step(1,1,2'b11,2'b11,2'b00,2'b00,0,F_MSOP|F_SOPO,1,0,"R4_multi_sop");
    clear(1, "R4_clear");
    // R6: start in lower segment while open
    step(1,1,2'b01,2'b01,2'b00,2'b00,0,F_SOPO,1,0,"R6_sop_open");
    clear(1, "R6_clear");
    step(1,1,2'b01,2'b00,2'b01,2'b00,0,'0,0,1,"R6_close");

    // R5 R7: two ends in one cycle, the second without a packet
    step(1,1,2'b01,2'b01,2'b00,2'b00,0,'0,1,0,"R5_open");
    step(1,1,2'b11,2'b00,2'b11,2'b00,0,F_MEOP|F_ORPH,0,1,"R5_multi_eop");
    clear(0, "R5_clear");

    // R7: payload with no open packet
    step(1,1,2'b01,2'b00,2'b00,2'b00,0,F_ORPH,0,0,"R7_orphan_data");
    clear(0, "R7_clear");

    // R8: error on a non-end transfer, then legal and ignored cases
    step(1,1,2'b01,2'b01,2'b00,2'b01,0,F_ERRM,1,0,"R8_err_mid");
    clear(1, "R8_clear");
    step(1,1,2'b11,2'b00,2'b10,2'b10,0,'0,0,1,"R8_err_on_eop");
    step(1,1,2'b01,2'b01,2'b00,2'b10,0,'0,1,0,"R8_err_disabled_seg");
    step(1,1,2'b01,2'b00,2'b01,2'b00,0,'0,0,1,"R8_close");

    // R9: upper segment used while lower is idle inside a packet
    step(1,1,2'b01,2'b01,2'b00,2'b00,0,'0,1,0,"R9_open");
    step(1,1,2'b10,2'b00,2'b00,2'b00,0,F_GAP,1,0,"R9_gap");
    clear(1, "R9_clear");
    step(1,1,2'b01,2'b00,2'b01,2'b00,0,'0,0,1,"R9_close");

    // R11: clear wins over a violation in the same cycle
    step(1,1,2'b01,2'b00,2'b00,2'b00,1,F_ORPH,0,0,"R11_clear_priority");
    idle(0, "R11_after_priority");

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule